// File: doc/BRIEF.md
# Configurable Serial Transceiver with Parity

This block is a matched asynchronous serial transmitter and receiver sharing one 8-bit control register. The register picks the frame width (8 or 9 payload bits between a low start bit and a high stop bit), whether a parity bit is generated and checked, the parity sense, the way a muted receiver wakes up, and a low-power hold. Timing comes from an external baud tick running at sixteen times the bit rate. The transmitter shifts out one bit per sixteen ticks. The receiver finds the start edge and samples every bit at its centre.

When parity is on, the parity bit takes the place of the last payload bit rather than lengthening the frame. Frame width and parity settings are captured when each frame begins, so rewriting the register mid-frame only affects the next frame. A receiver can be muted by a strobe. It then drops frames until an address-marked frame arrives, or until the line has stayed high for a whole frame time, depending on the wake-up setting.

Top module: `sercom_xcvr`

## Requirements
- R1: After reset the control register reads 0 in every bit except bit 6 (received ninth bit, value unspecified), `txd` is high, both error flags are low and the receiver is not muted.
- R2: Control bits: 0 odd parity sense, 1 parity enable, 2 wake-up by address mark (0 = idle line), 3 nine-bit payload, 4 low-power hold, 5 ninth transmit bit; bit 6 reads back the ninth received bit. A `tx_start` pulse while idle sends a low start bit, the 8 data bits least significant first and a high stop bit, each lasting 16 baud ticks.
- R3: With bit 3 set, a ninth payload bit is sent after the data bits, taken from control bit 5. A received ninth bit is stored in control bit 6.
- R4: With parity enabled, the last payload bit (bit 8 of a 9-bit payload, bit 7 of an 8-bit payload) is replaced by parity over the lower payload bits. It is even (total ones including parity even) when bit 0 is 0 and odd when bit 0 is 1.
- R5: With parity enabled, a received frame whose last payload bit disagrees with the parity of the lower bits sets the sticky `par_err` until `err_clr`. `rx_data` always shows the 8 lowest payload bits as received, and `rx_valid` pulses once per accepted frame.
- R6: Frame width, parity enable and parity sense are taken at the start of each frame. Register writes during a frame change neither that frame's bits nor its length.
- R7: While bit 4 is set, no new frame starts in either direction, so `tx_start` and incoming frames are ignored and `txd` stays high. A frame already in progress completes. Clearing the bit restores normal operation.
- R8: The receiver samples each bit at its middle. A low stop bit sets the sticky `frm_err` until `err_clr`.
- R9: In address-mark mode, a receiver muted by `rx_mute_req` discards frames whose last payload bit is 0. The first frame whose last payload bit is 1 clears the mute and is delivered.
- R10: In idle-line mode, a muted receiver discards frames and unmutes once the line has been continuously high for one frame time (160 ticks for 8-bit, 176 for 9-bit payloads), counted from the mute request or the last low level.
- R11: A `tx_start` pulse while a frame is being sent is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | Oversampling tick, 16 per bit |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write value |
| ctl_rdata | output | 8 | Control register readback |
| tx_data | input | 8 | Byte to transmit |
| tx_start | input | 1 | Start a transmit frame |
| tx_busy | output | 1 | Transmit frame in progress |
| txd | output | 1 | Serial output line |
| rxd | input | 1 | Serial input line |
| rx_data | output | 8 | Last accepted received byte |
| rx_valid | output | 1 | One-cycle pulse per accepted frame |
| rx_mute_req | input | 1 | Put the receiver into mute |
| rx_muted | output | 1 | Receiver is muted |
| err_clr | input | 1 | Clear both error flags |
| par_err | output | 1 | Sticky parity error |
| frm_err | output | 1 | Sticky framing error |

## Verification
The hardest situations to reach are a register rewrite that lands inside a frame and the exact moment an idle-line mute expires. The first needs a write timed within a live frame, and the second depends on an unbroken count of high-line ticks. The bench forks a register write (or a second start pulse) a fixed number of cycles into a transmit frame and checks both the bits and the frame length against the format in force at the start. For muting, it counts cycles from the mute strobe and from the last low line level, and checks the mute flag just before and just after the frame time. Random frames in all width and parity combinations, some with the parity bit flipped, cover the normal paths.

// File: rtl/sercom_pkg.sv
package sercom_pkg;
  localparam int DW = 8;          // data byte width
  localparam int PW = DW + 1;     // widest payload
  localparam int FW = PW + 2;     // widest frame: start + payload + stop

  // control register bit positions
  localparam int B_ODD   = 0;
  localparam int B_PE    = 1;
  localparam int B_WADDR = 2;
  localparam int B_WIDE  = 3;
  localparam int B_SLEEP = 4;
  localparam int B_T9    = 5;
  localparam int CFG_W   = 6;

  typedef struct packed {
    logic wide;
    logic pe;
    logic odd;
  } fmt_t;

  // parity over the payload bits below the last one
  function automatic logic low_parity(input logic [PW-1:0] p, input logic wide,
                                      input logic odd);
    logic r;
    r = odd;
    for (int i = 0; i < DW; i++)
      if (wide || i < DW - 1) r = r ^ p[i];
    return r;
  endfunction

  function automatic logic frame_msb(input logic [PW-1:0] p, input logic wide);
    return wide ? p[DW] : p[DW-1];
  endfunction

  // payload as it goes on the line; an unused top position idles high
  function automatic logic [PW-1:0] build_payload(input logic [DW-1:0] d,
                                                  input logic t9, input fmt_t f);
    logic [PW-1:0] p;
    p = {t9, d};
    if (f.pe) begin
      if (f.wide) p[DW]   = low_parity(p, 1'b1, f.odd);
      else        p[DW-1] = low_parity(p, 1'b0, f.odd);
    end
    if (!f.wide) p[DW] = 1'b1;
    return p;
  endfunction
endpackage

// File: rtl/sercom_tx.sv
module sercom_tx import sercom_pkg::*; #(
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start,
  input  logic          sleep,
  input  logic [DW-1:0] data,
  input  logic          t9,
  input  fmt_t          fmt,
  output logic          busy,
  output logic          line
);
  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(FW + 1);

  logic [FW-1:0] sh;
  logic [CW-1:0] cnt;
  logic [BW-1:0] nleft;
  logic          bit_end;

  assign bit_end = tick && (cnt == CW'(OVS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      sh    <= '1;
      cnt   <= '0;
      nleft <= '0;
    end else if (!busy) begin
      if (start && !sleep) begin
        busy  <= 1'b1;
        sh    <= {1'b1, build_payload(data, t9, fmt), 1'b0};
        cnt   <= '0;
        nleft <= fmt.wide ? BW'(FW) : BW'(FW - 1);
      end
    end else if (bit_end) begin
      cnt   <= '0;
      sh    <= {1'b1, sh[FW-1:1]};
      nleft <= nleft - BW'(1);
      if (nleft == BW'(1)) busy <= 1'b0;
    end else if (tick) begin
      cnt <= cnt + CW'(1);
    end
  end

  assign line = busy ? sh[0] : 1'b1;
endmodule

// File: rtl/sercom_rx.sv
module sercom_rx import sercom_pkg::*; #(
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rxd,
  input  logic          sleep,
  input  fmt_t          fmt,
  input  logic          wake_addr,
  input  logic          mute_req,
  output logic          idle,
  output logic          muted,
  output logic          done,
  output logic [PW-1:0] pld,
  output logic          wide_o,
  output logic          par_bad,
  output logic          stop_bad
);
  localparam int CW = $clog2(OVS);
  localparam int NW = $clog2(PW + 1);
  localparam int LW = $clog2(FW * OVS + 1);

  typedef enum logic [1:0] {R_IDLE, R_START, R_DATA, R_STOP} rstate_e;

  rstate_e       st;
  logic          s1, s2, s3;
  fmt_t          fl;
  logic [PW-1:0] sh;
  logic [CW-1:0] cnt;
  logic [NW-1:0] nb;
  logic [LW-1:0] hi_cnt;

  logic          fall, half, mid, stop_smp, accept, idle_wake, msb;
  logic [PW-1:0] aligned;
  logic [LW-1:0] ft;
  logic [NW-1:0] last_bit;

  assign fall      = s3 & ~s2;
  assign half      = tick && (cnt == CW'(OVS / 2 - 1));
  assign mid       = tick && (cnt == CW'(OVS - 1));
  assign aligned   = fl.wide ? sh : {1'b0, sh[PW-1:1]};
  assign msb       = frame_msb(aligned, fl.wide);
  assign last_bit  = fl.wide ? NW'(PW - 1) : NW'(DW - 1);
  assign stop_smp  = (st == R_STOP) && mid;
  assign accept    = stop_smp && (!muted || (wake_addr && msb));
  assign ft        = fmt.wide ? LW'(FW * OVS) : LW'((FW - 1) * OVS);
  assign idle_wake = muted && !wake_addr && (hi_cnt >= ft);
  assign idle      = (st == R_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b1; s2 <= 1'b1; s3 <= 1'b1;
    end else begin
      s1 <= rxd; s2 <= s1; s3 <= s2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= R_IDLE;
      cnt <= '0;
      nb  <= '0;
      sh  <= '0;
      fl  <= '0;
    end else begin
      case (st)
        R_IDLE:
          if (fall && !sleep) begin
            st  <= R_START;
            cnt <= '0;
            fl  <= fmt;
          end
        R_START:
          if (half) begin
            cnt <= '0;
            nb  <= '0;
            st  <= s2 ? R_IDLE : R_DATA;
          end else if (tick) cnt <= cnt + CW'(1);
        R_DATA:
          if (mid) begin
            cnt <= '0;
            sh  <= {s2, sh[PW-1:1]};
            if (nb == last_bit) st <= R_STOP;
            else nb <= nb + NW'(1);
          end else if (tick) cnt <= cnt + CW'(1);
        default:
          if (mid) st <= R_IDLE;
          else if (tick) cnt <= cnt + CW'(1);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done     <= 1'b0;
      pld      <= '0;
      wide_o   <= 1'b0;
      par_bad  <= 1'b0;
      stop_bad <= 1'b0;
    end else begin
      done <= accept;
      if (accept) begin
        pld      <= aligned;
        wide_o   <= fl.wide;
        par_bad  <= fl.pe && (msb != low_parity(aligned, fl.wide, fl.odd));
        stop_bad <= ~s2;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      muted  <= 1'b0;
      hi_cnt <= '0;
    end else begin
      if (mute_req) muted <= 1'b1;
      else if (accept || idle_wake) muted <= 1'b0;
      if (mute_req || !s2) hi_cnt <= '0;
      else if (tick && hi_cnt < ft) hi_cnt <= hi_cnt + LW'(1);
    end
  end
endmodule

// File: rtl/sercom_xcvr.sv
module sercom_xcvr import sercom_pkg::*; #(
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic          ctl_wr,
  input  logic [7:0]    ctl_wdata,
  output logic [7:0]    ctl_rdata,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_start,
  output logic          tx_busy,
  output logic          txd,
  input  logic          rxd,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  input  logic          rx_mute_req,
  output logic          rx_muted,
  input  logic          err_clr,
  output logic          par_err,
  output logic          frm_err
);
  logic [CFG_W-1:0] cfg;
  logic             rx9;
  fmt_t             fmt;
  logic             sleep_req, rx_idle, halted, tx_line;
  logic             rx_done, rx_wide, rx_pbad, rx_sbad;
  logic [PW-1:0]    rx_pld;
  logic             unused_wbits;

  assign unused_wbits = ^ctl_wdata[7:CFG_W];
  assign fmt.wide  = cfg[B_WIDE];
  assign fmt.pe    = cfg[B_PE];
  assign fmt.odd   = cfg[B_ODD];
  assign sleep_req = cfg[B_SLEEP];
  assign halted    = sleep_req && !tx_busy && rx_idle;

  always_ff @(posedge clk) begin
    if (!rst_n) cfg <= '0;
    else if (ctl_wr) cfg <= ctl_wdata[CFG_W-1:0];
  end

  sercom_tx #(.OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .start(tx_start),
    .sleep(sleep_req), .data(tx_data), .t9(cfg[B_T9]), .fmt(fmt),
    .busy(tx_busy), .line(tx_line)
  );

  sercom_rx #(.OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .rxd(rxd), .sleep(sleep_req),
    .fmt(fmt), .wake_addr(cfg[B_WADDR]), .mute_req(rx_mute_req),
    .idle(rx_idle), .muted(rx_muted), .done(rx_done), .pld(rx_pld),
    .wide_o(rx_wide), .par_bad(rx_pbad), .stop_bad(rx_sbad)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx9     <= 1'b0;
      par_err <= 1'b0;
      frm_err <= 1'b0;
    end else begin
      if (rx_done && rx_wide) rx9 <= rx_pld[DW];
      if (rx_done && rx_pbad) par_err <= 1'b1;
      else if (err_clr)       par_err <= 1'b0;
      if (rx_done && rx_sbad) frm_err <= 1'b1;
      else if (err_clr)       frm_err <= 1'b0;
    end
  end

  assign txd       = halted ? 1'b1 : tx_line;
  assign rx_data   = rx_pld[DW-1:0];
  assign rx_valid  = rx_done;
  assign ctl_rdata = {1'b0, rx9, cfg};
endmodule

module sercom_chk (
  input logic clk,
  input logic rst_n,
  input logic txd,
  input logic tx_busy,
  input logic sleep_req,
  input logic halted,
  input logic rx_valid,
  input logic rx_muted,
  input logic err_clr,
  input logic par_err,
  input logic frm_err
);
  a_r2_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);
  a_r7_no_start_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_req && !tx_busy) |=> !tx_busy);
  a_r7_no_rx_when_halted: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> !rx_valid);
  a_r5_par_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err && !err_clr) |=> par_err);
  a_r8_frm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_err && !err_clr) |=> frm_err);
  a_r9_valid_unmuted: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !rx_muted);
endmodule

bind sercom_xcvr sercom_chk u_chk (
  .clk(clk), .rst_n(rst_n), .txd(txd), .tx_busy(tx_busy),
  .sleep_req(sleep_req), .halted(halted), .rx_valid(rx_valid),
  .rx_muted(rx_muted), .err_clr(err_clr), .par_err(par_err), .frm_err(frm_err)
);

// File: tb/sim_sercom_xcvr.sv
module sim_sercom_xcvr;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, baud_tick, ctl_wr, tx_start, tx_busy, txd, rxd, rx_valid;
  logic       rx_mute_req, rx_muted, err_clr, par_err, frm_err;
  logic [7:0] ctl_wdata, ctl_rdata, tx_data, rx_data;

  int total = 0, bad = 0, got_n = 0, n0;
  logic [7:0]  got_d;
  logic [10:0] cap, ef;
  bit finished = 0;

  sercom_xcvr u0 (.*);

  always @(negedge clk) if (rx_valid) begin got_n++; got_d = rx_data; end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mk(bit odd, bit pe, bit waddr, bit wide, bit slp, bit t9);
    return {2'b00, t9, slp, wide, waddr, pe, odd};
  endfunction

  // serial bit sequence, index 0 is the start bit
  function automatic logic [10:0] ref_frame(logic [7:0] d, bit t9, bit wide, bit pe, bit odd);
    logic [10:0] f;
    int nd, ones;
    nd = wide ? 9 : 8;
    f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < 8; i++) f[i+1] = d[i];
    if (wide) f[9] = t9;
    if (pe) begin
      ones = 0;
      for (int i = 1; i < nd; i++) ones += int'(f[i]);
      f[nd] = ((ones % 2) == 1) ^ odd;
    end
    return f;
  endfunction

  task automatic set_ctl(input logic [7:0] v);
    @(negedge clk); ctl_wdata = v; ctl_wr = 1'b1;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
  endtask

  task automatic pulse_mute();
    @(negedge clk); rx_mute_req = 1'b1; @(negedge clk); rx_mute_req = 1'b0;
  endtask

  task automatic tx_go(input logic [7:0] d);
    @(negedge clk); tx_data = d; tx_start = 1'b1;
    @(negedge clk); tx_start = 1'b0;
  endtask

  task automatic tx_capture(input int nbits, output logic [10:0] g);
    int w;
    w = 0;
    g = '1;
    while (txd !== 1'b0 && w < 400) begin @(negedge clk); w++; end
    repeat (8) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin g[i] = txd; repeat (16) @(negedge clk); end
  endtask

  task automatic rx_drive(input logic [10:0] f, input int nbits);
    for (int i = 0; i < nbits; i++) begin rxd = f[i]; repeat (16) @(negedge clk); end
    rxd = 1'b1;
    repeat (24) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [10:0] m;
    bit all_hi;
    void'($urandom(7771));
    rst_n = 0; baud_tick = 1; ctl_wr = 0; ctl_wdata = 0; tx_start = 0; tx_data = 0;
    rxd = 1; rx_mute_req = 0; err_clr = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk((ctl_rdata & 8'hBF) == 0, "R1 ctl reset", ctl_rdata, 0);
    chk(txd == 1 && par_err == 0 && frm_err == 0 && rx_muted == 0, "R1 outputs reset",
        {txd, par_err, frm_err, rx_muted}, 4'b1000);

    // transmit, random formats: R2 R3 R4
    for (int k = 0; k < 24; k++) begin
      bit wide, pe, odd, t9;
      logic [7:0] d;
      int nb;
      wide = 1'($urandom); pe = 1'($urandom); odd = 1'($urandom); t9 = 1'($urandom);
      d = 8'($urandom);
      nb = wide ? 11 : 10;
      m = wide ? 11'h7FF : 11'h3FF;
      set_ctl(mk(odd, pe, 0, wide, 0, t9));
      tx_go(d);
      tx_capture(nb, cap);
      ef = ref_frame(d, t9, wide, pe, odd);
      chk((cap & m) == (ef & m), pe ? "R4 tx parity frame" : (wide ? "R3 tx nine-bit frame" : "R2 tx frame"),
          cap & m, ef & m);
      while (tx_busy) @(negedge clk);
    end

    // receive, random formats with some parity flips: R5 R3 R8
    for (int k = 0; k < 24; k++) begin
      bit wide, pe, odd, t9, bad_p;
      logic [7:0] d;
      int nd;
      wide = 1'($urandom); pe = 1'($urandom); odd = 1'($urandom); t9 = 1'($urandom);
      d = 8'($urandom);
      nd = wide ? 9 : 8;
      bad_p = pe && (($urandom % 4) == 0);
      ef = ref_frame(d, t9, wide, pe, odd);
      if (bad_p) ef[nd] = ~ef[nd];
      set_ctl(mk(odd, pe, 0, wide, 0, 0));
      pulse_clr();
      n0 = got_n;
      rx_drive(ef, nd + 2);
      chk(got_n == n0 + 1, "R5 rx one valid", got_n - n0, 1);
      chk(got_d == ef[8:1], "R8 rx data mid-bit", got_d, ef[8:1]);
      if (wide) chk(ctl_rdata[6] == ef[9], "R3 rx ninth bit", ctl_rdata[6], ef[9]);
      chk(par_err == bad_p, "R5 parity flag", par_err, bad_p);
      chk(frm_err == 0, "R8 no framing error", frm_err, 0);
    end

    // R5 stickiness
    set_ctl(mk(0, 1, 0, 0, 0, 0));
    pulse_clr();
    ef = ref_frame(8'h35, 0, 0, 1, 0); ef[8] = ~ef[8];
    rx_drive(ef, 10);
    rx_drive(ref_frame(8'h35, 0, 0, 1, 0), 10);
    chk(par_err == 1, "R5 parity error sticky", par_err, 1);
    pulse_clr();
    chk(par_err == 0, "R5 parity error cleared", par_err, 0);

    // R6 parity enabled mid-frame: current frame unchanged, next uses parity
    set_ctl(mk(0, 0, 0, 0, 0, 0));
    tx_go(8'h83);
    fork
      tx_capture(10, cap);
      begin repeat (40) @(negedge clk); set_ctl(mk(0, 1, 0, 0, 0, 0)); end
    join
    ef = ref_frame(8'h83, 0, 0, 0, 0);
    chk(cap[9:0] == ef[9:0], "R6 frame keeps old parity mode", cap[9:0], ef[9:0]);
    while (tx_busy) @(negedge clk);
    tx_go(8'h83);
    tx_capture(10, cap);
    ef = ref_frame(8'h83, 0, 0, 1, 0);
    chk(cap[9:0] == ef[9:0], "R6 next frame uses parity", cap[9:0], ef[9:0]);
    while (tx_busy) @(negedge clk);

    // R6 width widened mid-frame: length stays ten bits
    set_ctl(mk(0, 0, 0, 0, 0, 0));
    tx_go(8'hC6);
    fork
      tx_capture(10, cap);
      begin repeat (50) @(negedge clk); set_ctl(mk(0, 0, 0, 1, 0, 0)); end
    join
    chk(tx_busy == 0, "R6 frame length fixed at start", tx_busy, 0);
    ef = ref_frame(8'hC6, 0, 0, 0, 0);
    chk(cap[9:0] == ef[9:0], "R6 frame bits fixed at start", cap[9:0], ef[9:0]);

    // R11 start while busy ignored
    set_ctl(mk(0, 0, 0, 0, 0, 0));
    tx_go(8'h5A);
    fork
      tx_capture(10, cap);
      begin
        repeat (30) @(negedge clk);
        tx_data = 8'hFF; tx_start = 1'b1;
        @(negedge clk); tx_start = 1'b0;
      end
    join
    ef = ref_frame(8'h5A, 0, 0, 0, 0);
    chk(cap[9:0] == ef[9:0], "R11 first frame intact", cap[9:0], ef[9:0]);
    all_hi = 1;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (txd !== 1'b1 || tx_busy) all_hi = 0; end
    chk(all_hi, "R11 no second frame", all_hi, 1);

    // R7 low-power hold
    tx_go(8'h3C);
    fork
      tx_capture(10, cap);
      begin repeat (30) @(negedge clk); set_ctl(mk(0, 0, 0, 0, 1, 0)); end
    join
    ef = ref_frame(8'h3C, 0, 0, 0, 0);
    chk(cap[9:0] == ef[9:0], "R7 frame in progress completes", cap[9:0], ef[9:0]);
    while (tx_busy) @(negedge clk);
    tx_go(8'h11);
    all_hi = 1;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (txd !== 1'b1 || tx_busy) all_hi = 0; end
    chk(all_hi, "R7 tx start ignored while held", all_hi, 1);
    n0 = got_n;
    rx_drive(ref_frame(8'h22, 0, 0, 0, 0), 10);
    chk(got_n == n0, "R7 rx frame ignored while held", got_n - n0, 0);
    set_ctl(mk(0, 0, 0, 0, 0, 0));
    tx_go(8'h11);
    tx_capture(10, cap);
    ef = ref_frame(8'h11, 0, 0, 0, 0);
    chk(cap[9:0] == ef[9:0], "R7 tx resumes", cap[9:0], ef[9:0]);
    n0 = got_n;
    rx_drive(ref_frame(8'h22, 0, 0, 0, 0), 10);
    chk(got_n == n0 + 1 && got_d == 8'h22, "R7 rx resumes", got_d, 8'h22);

    // R8 framing error, sticky then cleared
    pulse_clr();
    ef = ref_frame(8'h5A, 0, 0, 0, 0); ef[9] = 1'b0;
    rx_drive(ef, 10);
    chk(frm_err == 1, "R8 low stop sets error", frm_err, 1);
    rx_drive(ref_frame(8'h44, 0, 0, 0, 0), 10);
    chk(frm_err == 1, "R8 error sticky", frm_err, 1);
    pulse_clr();
    chk(frm_err == 0, "R8 error cleared", frm_err, 0);

    // R9 address-mark wake, 8-bit and 9-bit
    set_ctl(mk(0, 0, 1, 0, 0, 0));
    pulse_mute();
    chk(rx_muted == 1, "R9 mute set", rx_muted, 1);
    n0 = got_n;
    rx_drive(ref_frame(8'h12, 0, 0, 0, 0), 10);
    chk(got_n == n0 && rx_muted == 1, "R9 non-address frame dropped", got_n - n0, 0);
    rx_drive(ref_frame(8'h93, 0, 0, 0, 0), 10);
    chk(got_n == n0 + 1 && got_d == 8'h93, "R9 address frame delivered", got_d, 8'h93);
    chk(rx_muted == 0, "R9 unmuted by address", rx_muted, 0);
    set_ctl(mk(0, 0, 1, 1, 0, 0));
    pulse_mute();
    n0 = got_n;
    rx_drive(ref_frame(8'hFF, 0, 1, 0, 0), 11);
    chk(got_n == n0 && rx_muted == 1, "R9 wide frame ninth=0 dropped", got_n - n0, 0);
    rx_drive(ref_frame(8'h07, 1, 1, 0, 0), 11);
    chk(got_n == n0 + 1 && rx_muted == 0 && got_d == 8'h07, "R9 wide address frame", got_d, 8'h07);

    // R10 idle-line wake
    set_ctl(mk(0, 0, 0, 0, 0, 0));
    pulse_mute();
    repeat (145) @(negedge clk);
    chk(rx_muted == 1, "R10 still muted before frame time", rx_muted, 1);
    repeat (20) @(negedge clk);
    chk(rx_muted == 0, "R10 unmuted after frame time", rx_muted, 0);
    pulse_mute();
    n0 = got_n;
    rx_drive(ref_frame(8'h55, 0, 0, 0, 0), 10);
    chk(got_n == n0 && rx_muted == 1, "R10 frame dropped while muted", got_n - n0, 0);
    repeat (150) @(negedge clk);
    chk(rx_muted == 0, "R10 unmuted after idle line", rx_muted, 0);
    rx_drive(ref_frame(8'hA9, 0, 0, 0, 0), 10);
    chk(got_n == n0 + 1 && got_d == 8'hA9, "R10 delivers after wake", got_d, 8'hA9);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule